// File: doc/BRIEF.md
# DMA Read Request Header Builder

This block turns DMA read commands into memory read request headers for a PCIe transaction layer. Each command carries a 64-bit byte address, a length in dwords, the byte enables for the first and last dword, a lock flag, a requested traffic class and a 16-bit requester ID. The block chooses the header format from the address, chooses the request type from the lock flag, settles the traffic class, and raises a flag on zero-length reads. It places the finished header in an output register that uses a valid/ready handshake.

A command is accepted only when a tag can be taken from an internal pool of 32 tags. The lowest-numbered free tag is used. A command that cannot get a tag waits at the input and is not dropped. Tags come back to the pool through a release port once the last completion for a request has been handled. The bus number of the requester is stored with each outstanding tag, and a lookup port reads it back for address translation.

Top module: `dmard_req_builder`

## Requirements
- R1: After reset, hdr_valid and tag_err are 0, and cmd_ready is 1 because every tag is free.
- R2: When address bits 63:32 hold any 1, the header uses the 4DW form: DW0 bits 31:29 = 3'b001, DW2 = address bits 63:32, DW3 = address bits 31:0 with bits 1:0 cleared, and hdr_is_4dw = 1. Otherwise DW0 bits 31:29 = 3'b000, DW2 = address bits 31:0 with bits 1:0 cleared, DW3 = 0, and hdr_is_4dw = 0.
- R3: A locked command gives type 5'b00001 in DW0 bits 28:24 and forces the traffic class in DW0 bits 22:20 to 0, whatever class was requested.
- R4: An unlocked command gives type 5'b00000. Its traffic class is cmd_tc bits 2:0, except that cmd_tc = 4'hF (the unset marker, -1) selects the default class 0.
- R5: hdr_zero_len is 1 exactly when the length field is 1 and both the first and last byte enables are 4'b0000.
- R6: DW0 bits 9:0 hold the length. DW1 holds the requester ID in bits 31:16, the tag in bits 15:8, the last byte enables in bits 7:4 and the first byte enables in bits 3:0. The tag is the lowest-numbered free tag in the pool.
- R7: While no tag is free, cmd_ready is 0 and the waiting command is held. It is accepted as soon as a tag is released.
- R8: A release returns its tag to the pool. Releasing a tag that is already free sets tag_err, which stays set until reset, and leaves the pool unchanged.
- R9: hdr_valid stays high with stable header contents until hdr_ready is seen. At most one command is accepted per cycle, and only when the output register is empty or being drained.
- R10: lkup_bus shows, one cycle after lkup_tag, the requester bus number (requester ID bits 15:8) of the command that holds that tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_addr | input | 64 | Byte address |
| cmd_len | input | 10 | Length in dwords (0 means 1024) |
| cmd_first_be | input | 4 | First dword byte enables |
| cmd_last_be | input | 4 | Last dword byte enables |
| cmd_lock | input | 1 | Locked read |
| cmd_tc | input | 4 | Traffic class, 4'hF = unset |
| cmd_req_id | input | 16 | Requester ID |
| hdr_valid | output | 1 | Header present |
| hdr_ready | input | 1 | Header taken |
| hdr_words | output | 128 | DW3..DW0, DW0 in bits 31:0 |
| hdr_is_4dw | output | 1 | 4DW header form |
| hdr_zero_len | output | 1 | Zero-length read |
| rel_valid | input | 1 | Tag release strobe |
| rel_tag | input | 5 | Tag being released |
| tag_err | output | 1 | Sticky double-release error |
| lkup_tag | input | 5 | Tag to look up |
| lkup_bus | output | 8 | Bus number stored for lkup_tag |

## Verification
Random commands mix 32-bit and 64-bit addresses, locked and unlocked reads, set and unset traffic classes, and lengths of one dword with byte enables at zero. Together these separate the format choice, the override of the class on locked reads, and the zero-length flag. A random hdr_ready with releases in the same cycle as allocations checks that the lowest free tag is used and that headers are held under back-pressure. Directed runs fill all 32 tags to show the stall, release one tag to see that exact tag reused, and release a free tag twice to check that the error flag is sticky and that the pool does not change.

// File: rtl/dmard_pkg.sv
package dmard_pkg;
  localparam logic [2:0] FMT_3DW_NODATA = 3'b000;
  localparam logic [2:0] FMT_4DW_NODATA = 3'b001;
  localparam logic [4:0] TYPE_MEMRD     = 5'b00000;
  localparam logic [4:0] TYPE_MEMRD_LK  = 5'b00001;
  localparam logic [3:0] TC_NONE        = 4'hF;

  typedef struct packed {
    logic [63:0] addr;
    logic [9:0]  len;
    logic [3:0]  fbe;
    logic [3:0]  lbe;
    logic        lock;
    logic [3:0]  tc;
    logic [15:0] rid;
  } rd_cmd_t;
endpackage

// File: rtl/dmard_tag_pool.sv
module dmard_tag_pool #(
  parameter int NUM_TAGS = 32,
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  output logic             avail,
  output logic [TAG_W-1:0] free_tag,
  input  logic             rel_valid,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             err
);
  logic [NUM_TAGS-1:0] free_q;
  logic [NUM_TAGS-1:0] take_mask, give_mask;
  logic                rel_ok;

  assign avail = |free_q;

  always_comb begin
    free_tag = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--)
      if (free_q[i]) free_tag = TAG_W'(i);
  end

  assign rel_ok    = rel_valid && !free_q[rel_tag];
  assign take_mask = (alloc && avail) ? (NUM_TAGS'(1) << free_tag) : '0;
  assign give_mask = rel_ok ? (NUM_TAGS'(1) << rel_tag) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= '1;
      err    <= 1'b0;
    end else begin
      free_q <= (free_q & ~take_mask) | give_mask;
      if (rel_valid && free_q[rel_tag]) err <= 1'b1;
    end
  end
endmodule

// File: rtl/dmard_bus_table.sv
module dmard_bus_table #(
  parameter int DEPTH = 32,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dmard_hdr_format.sv
module dmard_hdr_format
  import dmard_pkg::*;
#(
  parameter int TAG_W = 5,
  parameter logic [2:0] DEFAULT_TC = 3'd0
) (
  input  rd_cmd_t          cmd,
  input  logic [TAG_W-1:0] tag,
  output logic [127:0]     words,
  output logic             is_4dw,
  output logic             zero_len
);
  logic [2:0]  tc_sel;
  logic [31:0] dw0, dw1, dw2, dw3;
  logic [7:0]  tag8;

  assign is_4dw   = |cmd.addr[63:32];
  assign zero_len = (cmd.len == 10'd1) && (cmd.fbe == 4'd0) && (cmd.lbe == 4'd0);
  assign tag8     = 8'(tag);

  always_comb begin
    if (cmd.lock)                tc_sel = 3'd0;
    else if (cmd.tc == TC_NONE)  tc_sel = DEFAULT_TC;
    else                         tc_sel = cmd.tc[2:0];
  end

  always_comb begin
    dw0 = '0;
    dw0[31:29] = is_4dw ? FMT_4DW_NODATA : FMT_3DW_NODATA;
    dw0[28:24] = cmd.lock ? TYPE_MEMRD_LK : TYPE_MEMRD;
    dw0[22:20] = tc_sel;
    dw0[9:0]   = cmd.len;
    dw1 = {cmd.rid, tag8, cmd.lbe, cmd.fbe};
    if (is_4dw) begin
      dw2 = cmd.addr[63:32];
      dw3 = {cmd.addr[31:2], 2'b00};
    end else begin
      dw2 = {cmd.addr[31:2], 2'b00};
      dw3 = '0;
    end
    words = {dw3, dw2, dw1, dw0};
  end
endmodule

// File: rtl/dmard_req_builder.sv
module dmard_req_builder
  import dmard_pkg::*;
#(
  parameter int NUM_TAGS = 32,
  parameter logic [2:0] DEFAULT_TC = 3'd0,
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [63:0]      cmd_addr,
  input  logic [9:0]       cmd_len,
  input  logic [3:0]       cmd_first_be,
  input  logic [3:0]       cmd_last_be,
  input  logic             cmd_lock,
  input  logic [3:0]       cmd_tc,
  input  logic [15:0]      cmd_req_id,
  output logic             hdr_valid,
  input  logic             hdr_ready,
  output logic [127:0]     hdr_words,
  output logic             hdr_is_4dw,
  output logic             hdr_zero_len,
  input  logic             rel_valid,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             tag_err,
  input  logic [TAG_W-1:0] lkup_tag,
  output logic [7:0]       lkup_bus
);
  rd_cmd_t          cmd;
  logic             accept, pool_avail;
  logic [TAG_W-1:0] new_tag;
  logic [127:0]     fmt_words;
  logic             fmt_4dw, fmt_zero;

  assign cmd = '{addr: cmd_addr, len: cmd_len, fbe: cmd_first_be, lbe: cmd_last_be,
                 lock: cmd_lock, tc: cmd_tc, rid: cmd_req_id};

  assign cmd_ready = pool_avail && (!hdr_valid || hdr_ready);
  assign accept    = cmd_valid && cmd_ready;

  dmard_tag_pool #(.NUM_TAGS(NUM_TAGS)) u_pool (
    .clk(clk), .rst(rst), .alloc(accept), .avail(pool_avail), .free_tag(new_tag),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .err(tag_err)
  );

  dmard_bus_table #(.DEPTH(NUM_TAGS), .DATA_W(8)) u_bus (
    .clk(clk), .we(accept), .waddr(new_tag), .wdata(cmd_req_id[15:8]),
    .raddr(lkup_tag), .rdata(lkup_bus)
  );

  dmard_hdr_format #(.TAG_W(TAG_W), .DEFAULT_TC(DEFAULT_TC)) u_fmt (
    .cmd(cmd), .tag(new_tag), .words(fmt_words), .is_4dw(fmt_4dw), .zero_len(fmt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_valid    <= 1'b0;
      hdr_words    <= '0;
      hdr_is_4dw   <= 1'b0;
      hdr_zero_len <= 1'b0;
    end else if (accept) begin
      hdr_valid    <= 1'b1;
      hdr_words    <= fmt_words;
      hdr_is_4dw   <= fmt_4dw;
      hdr_zero_len <= fmt_zero;
    end else if (hdr_ready) begin
      hdr_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/dmard_req_builder_chk.sv
module dmard_req_builder_chk (
  input logic         clk,
  input logic         rst,
  input logic         hdr_valid,
  input logic         hdr_ready,
  input logic [127:0] hdr_words,
  input logic         hdr_is_4dw,
  input logic         hdr_zero_len,
  input logic         tag_err
);
  // R9
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_words));

  // R2
  wide_addr_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && hdr_is_4dw |-> hdr_words[95:64] != 32'd0);

  // R3
  lock_tc_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && hdr_words[28:24] == 5'b00001 |-> hdr_words[22:20] == 3'd0);

  // R5
  zero_len_fields_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && hdr_zero_len |-> hdr_words[9:0] == 10'd1 && hdr_words[39:32] == 8'd0);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tag_err |=> tag_err);
endmodule

bind dmard_req_builder dmard_req_builder_chk u_chk (
  .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .hdr_words(hdr_words), .hdr_is_4dw(hdr_is_4dw), .hdr_zero_len(hdr_zero_len),
  .tag_err(tag_err)
);

// File: tb/dmard_req_builder_tb.sv
module dmard_req_builder_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, cmd_ready, cmd_lock = 0, hdr_valid, hdr_ready = 0;
  logic [63:0] cmd_addr = 0;
  logic [9:0] cmd_len = 0;
  logic [3:0] cmd_first_be = 0, cmd_last_be = 0, cmd_tc = 0;
  logic [15:0] cmd_req_id = 0;
  logic [127:0] hdr_words;
  logic hdr_is_4dw, hdr_zero_len, rel_valid = 0, tag_err;
  logic [4:0] rel_tag = 0, lkup_tag = 0;
  logic [7:0] lkup_bus;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_free;
  logic [31:0] m_emit;
  logic [7:0]  m_bus [32];
  logic [127:0] q_w[$];
  logic q_4[$], q_z[$];
  logic lk_pend = 0;
  logic [7:0] lk_exp;
  int last_tag;

  always #4 clk = ~clk;

  dmard_req_builder u_dut (.*);

  initial begin
    #1600000;
    n_fail++; n_tests++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_hdr(input logic [63:0] a, input logic [9:0] l,
      input logic [3:0] fb, input logic [3:0] lb, input logic lk, input logic [3:0] tc,
      input logic [15:0] rid, input int tag);
    logic [31:0] d0, d1, d2, d3;
    logic [2:0] t;
    t = lk ? 3'd0 : (tc == 4'hF ? 3'd0 : tc[2:0]);
    d0 = {(a[63:32] != 0) ? 3'b001 : 3'b000, lk ? 5'b00001 : 5'b00000, 1'b0, t, 10'd0, l};
    d1 = {rid, 8'(tag), lb, fb};
    if (a[63:32] != 0) begin d2 = a[63:32]; d3 = {a[31:2], 2'b00}; end
    else begin d2 = {a[31:2], 2'b00}; d3 = 32'd0; end
    return {d3, d2, d1, d0};
  endfunction

  function automatic int lowest_free(input logic [31:0] f);
    for (int i = 0; i < 32; i++) if (f[i]) return i;
    return -1;
  endfunction

  // One cycle: inputs already set; evaluate at negedge and update model.
  task automatic step();
    logic acc, xfer;
    int t;
    #1;
    if (lk_pend) begin
      chk("R10 lookup bus", 128'(lkup_bus), 128'(lk_exp));
      lk_pend = 0;
    end
    chk("R7/R9 cmd_ready", 128'(cmd_ready),
        128'((m_free != 0) && (!hdr_valid || hdr_ready)));
    acc  = cmd_valid && cmd_ready;
    xfer = hdr_valid && hdr_ready;
    if (xfer) begin
      if (q_w.size() == 0) chk("R9 unexpected header", 128'(1), 128'(0));
      else begin
        logic [127:0] w;
        w = q_w.pop_front();
        chk("R2/R3/R4/R6 header", hdr_words, w);
        chk("R2 is_4dw", 128'(hdr_is_4dw), 128'(q_4.pop_front()));
        chk("R5 zero_len", 128'(hdr_zero_len), 128'(q_z.pop_front()));
        m_emit[w[47:40]] = 1'b1;
      end
    end
    if (acc) begin
      t = lowest_free(m_free);
      last_tag = t;
      q_w.push_back(exp_hdr(cmd_addr, cmd_len, cmd_first_be, cmd_last_be, cmd_lock,
                            cmd_tc, cmd_req_id, t));
      q_4.push_back(cmd_addr[63:32] != 0);
      q_z.push_back(cmd_len == 10'd1 && cmd_first_be == 0 && cmd_last_be == 0);
      m_free[t] = 1'b0;
      m_bus[t] = cmd_req_id[15:8];
    end
    if (rel_valid && !m_free[rel_tag]) begin
      m_free[rel_tag] = 1'b1;
      m_emit[rel_tag] = 1'b0;
    end
    if (!m_free[lkup_tag] && !(acc && last_tag == int'(lkup_tag))) begin
      lk_pend = 1; lk_exp = m_bus[lkup_tag];
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rand_cmd();
    cmd_addr     = {($urandom_range(0, 1) ? $urandom : 32'd0), $urandom};
    cmd_len      = 10'($urandom);
    cmd_first_be = 4'($urandom);
    cmd_last_be  = 4'($urandom);
    if ($urandom_range(0, 5) == 0) begin cmd_len = 10'd1; cmd_first_be = 0; cmd_last_be = 0; end
    cmd_lock     = ($urandom_range(0, 4) == 0);
    cmd_tc       = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom_range(0, 7));
    cmd_req_id   = 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_free = '1; m_emit = '0;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 hdr_valid", 128'(hdr_valid), 128'(0));
    chk("R1 tag_err", 128'(tag_err), 128'(0));
    chk("R1 cmd_ready", 128'(cmd_ready), 128'(1));

    // Directed: R3 lock overrides TC, R4 unset TC, R5 zero-length, R2 both forms
    hdr_ready = 1; cmd_valid = 1;
    cmd_addr = 64'h0000_0001_2345_678F; cmd_len = 10'd1; cmd_first_be = 0; cmd_last_be = 0;
    cmd_lock = 1; cmd_tc = 4'd5; cmd_req_id = 16'hAB01;
    step();
    cmd_addr = 64'h0000_0000_DEAD_BEE4; cmd_lock = 0; cmd_tc = 4'hF; cmd_first_be = 4'hF;
    step();
    cmd_tc = 4'd6; cmd_len = 10'd0;
    step();
    cmd_valid = 0; step(); step();

    // R7 fill the pool with hdr_ready high, no releases
    cmd_valid = 1;
    while (m_free != 0) begin rand_cmd(); step(); end
    rand_cmd();
    step(); step();
    chk("R7 stall with empty pool", 128'(cmd_ready), 128'(0));
    rel_valid = 1; rel_tag = 5'd7;
    step();
    rel_valid = 0;
    step();
    chk("R7/R6 released tag reused", 128'(last_tag), 128'(7));
    cmd_valid = 0; step();

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      cmd_valid = ($urandom_range(0, 9) < 7);
      rand_cmd();
      hdr_ready = ($urandom_range(0, 9) < 7);
      rel_valid = 0;
      if ($urandom_range(0, 9) < 4 && m_emit != 0) begin
        int s;
        s = $urandom_range(0, 31);
        for (int k = 0; k < 32; k++)
          if (m_emit[(s + k) % 32] && !rel_valid) begin
            rel_valid = 1; rel_tag = 5'((s + k) % 32);
          end
      end
      lkup_tag = 5'($urandom);
      step();
    end
    rel_valid = 0; cmd_valid = 0; hdr_ready = 1;
    step(); step();
    chk("R8 no error from legal releases", 128'(tag_err), 128'(0));

    // R8 double release: release all, then release a free tag
    for (int k = 0; k < 32; k++) begin
      rel_valid = !m_free[k]; rel_tag = 5'(k); step();
    end
    rel_valid = 1; rel_tag = 5'd3;
    step();
    rel_valid = 0;
    step();
    chk("R8 tag_err set", 128'(tag_err), 128'(1));
    cmd_valid = 1; rand_cmd();
    step();
    cmd_valid = 0;
    step(); step();
    chk("R8 pool unchanged, lowest tag", 128'(last_tag), 128'(0));
    chk("R8 tag_err sticky", 128'(tag_err), 128'(1));
    chk("R9 all headers delivered", 128'(q_w.size()), 128'(0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule